// File: doc/BRIEF.md
# Parallel FIFO Bridge Host Controller

This block sits between a small 8-bit CPU and an external USB-to-parallel FIFO bridge chip. The bridge reports two active-low status lines, "a received byte is waiting" and "room to accept a byte for sending", and takes active-low read and write strobes over one shared 8-bit data bus. The controller brings both status lines into the clock domain through synchronisers and gives the CPU a ready flag per direction to poll. It also provides a one-byte write port and a one-byte read port.

A CPU write request latches the byte into a single pending slot. When the bridge reports space, the controller drives the byte for a set number of setup cycles, pulses the write strobe, and holds the byte for a set number of cycles after the strobe. A CPU read request waits until the bridge reports data. The controller then pulses the read strobe and captures the bus value on the last cycle before the strobe is released. After every transfer, a recovery interval passes before the status lines are acted on again.

The data bus is split into input, output and output-enable signals. The pad that joins them lies outside this block.

Top module: `pfifoBridge`

## Requirements
- R1: While reset is asserted and at release, `rdN` and `wrN` are 1, `busOe`, `busy` and `cpuRdValid` are 0.
- R2: With the default of two synchroniser stages, and with the block idle and nothing pending, a change on `txeN` or `rxfN` reaches `txReady` or `rxReady` after exactly two rising clock edges. `txReady` is 1 only when idle with no pending write and transmit space seen (line low). `rxReady` is the same for receive.
- R3: For a write, `busOe` is 1 and `busOut` carries the CPU byte for SETUP_CYC cycles before `wrN` goes low. `wrN` stays low for STROBE_CYC cycles. `busOe` and the byte then remain for HOLD_CYC cycles after `wrN` returns high.
- R4: A write starts only when the synchronised transmit-space line is low. A pending write is held for as long as it is high.
- R5: A write request arriving while an earlier write is pending (accepted but not yet started) is ignored. Each accepted request produces exactly one write strobe, carrying its own byte.
- R6: A read starts only when the synchronised receive line is low, and a read request is held until then. `rdN` stays low for STROBE_CYC cycles. In the first cycle after `rdN` returns high, `cpuRdValid` is 1 for that one cycle, and `cpuRdData` equals the bus value from the last low cycle.
- R7: `busOe` is 1 only inside write windows. `rdN` is never low while `busOe` is 1 or `wrN` is low.
- R8: Between the end of one transfer (`busOe` falling or `rdN` rising) and the start of the next (`busOe` rising or `rdN` falling), at least RECOVER_CYC cycles pass with the bus idle.
- R9: When a write and a read are both pending and both sides of the bridge are ready, the write goes first.
- R10: `busy` is 1 from the cycle after an accepted request until its recovery ends. While `busy` is 0, all strobes are inactive and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrReq | input | 1 | One-cycle request to send `cpuWrData` |
| cpuWrData | input | 8 | Byte to send |
| cpuRdReq | input | 1 | One-cycle request to fetch a received byte |
| cpuRdData | output | 8 | Last byte fetched from the bridge |
| cpuRdValid | output | 1 | One-cycle pulse when `cpuRdData` is new |
| txReady | output | 1 | A write may be issued and will start at once |
| rxReady | output | 1 | A received byte is waiting and no read is pending |
| busy | output | 1 | A request is pending or a transfer/recovery is running |
| rxfN | input | 1 | Bridge: received byte available, active low |
| txeN | input | 1 | Bridge: space to accept a byte, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| busIn | input | 8 | Data bus as seen from the pad |
| busOut | output | 8 | Data driven toward the pad |
| busOe | output | 1 | Output enable for the data bus pad |

## Verification
The embedded properties assume the bridge behaves like a FIFO chip. Its status lines change at most once per clock. Each line goes inactive within one clock of the matching strobe starting, and it settles before the synchronised value is used after recovery. The assumptions also need each CPU request to last one cycle. The bench's bridge model keeps to these rules. It drives both status lines one time unit after each rising edge and raises the relevant line at once while a strobe is low. It presents the front receive byte on `busIn` only while `rdN` is low. All CPU requests come from tasks that pulse for exactly one cycle.

// File: rtl/pfbPkg.sv
package pfbPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WHOLD,
    ST_RSTROBE,
    ST_RECOVER
  } pfbState_t;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic loadTx;   // capture a CPU byte into the pending slot
    logic oeOn;     // begin a write window (drive bus)
    logic oeOff;    // end a write window
    logic wrLow;    // assert the write strobe
    logic wrHigh;   // release the write strobe
    logic rdLow;    // assert the read strobe
    logic rdHigh;   // release the read strobe and capture bus
  } pfbStrobe_t;

endpackage

// File: rtl/pfbSync.sv
module pfbSync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= din;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= {STAGES{RST_VAL}};
        else       stageQ <= {stageQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/pfbCtl.sv
module pfbCtl
  import pfbPkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RECOVER_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrReq,
  input  logic       cpuRdReq,
  input  logic       txeOk,
  input  logic       rxfOk,
  output pfbStrobe_t stb,
  output logic       txPend,
  output logic       rxPend,
  output logic       idle
);

  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD = (HOLD_CYC > RECOVER_CYC) ? HOLD_CYC : RECOVER_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  pfbState_t     state, stateNext;
  logic [CW-1:0] cnt, cntNext;

  always_comb begin
    stateNext  = state;
    cntNext    = cnt;
    stb        = '0;
    stb.loadTx = cpuWrReq && !txPend;
    case (state)
      ST_IDLE: begin
        if (txPend && txeOk) begin
          stateNext = ST_WSETUP;
          cntNext   = CW'(SETUP_CYC - 1);
          stb.oeOn  = 1'b1;
        end else if (rxPend && rxfOk) begin
          stateNext = ST_RSTROBE;
          cntNext   = CW'(STROBE_CYC - 1);
          stb.rdLow = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (cnt == '0) begin
          stateNext = ST_WSTROBE;
          cntNext   = CW'(STROBE_CYC - 1);
          stb.wrLow = 1'b1;
        end else cntNext = cnt - CW'(1);
      end
      ST_WSTROBE: begin
        if (cnt == '0) begin
          stateNext  = ST_WHOLD;
          cntNext    = CW'(HOLD_CYC - 1);
          stb.wrHigh = 1'b1;
        end else cntNext = cnt - CW'(1);
      end
      ST_WHOLD: begin
        if (cnt == '0) begin
          stateNext = ST_RECOVER;
          cntNext   = CW'(RECOVER_CYC - 1);
          stb.oeOff = 1'b1;
        end else cntNext = cnt - CW'(1);
      end
      ST_RSTROBE: begin
        if (cnt == '0) begin
          stateNext  = ST_RECOVER;
          cntNext    = CW'(RECOVER_CYC - 1);
          stb.rdHigh = 1'b1;
        end else cntNext = cnt - CW'(1);
      end
      ST_RECOVER: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - CW'(1);
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      txPend <= 1'b0;
      rxPend <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (stb.oeOn)        txPend <= 1'b0;
      else if (stb.loadTx) txPend <= 1'b1;
      if (stb.rdLow)       rxPend <= 1'b0;
      else if (cpuRdReq)   rxPend <= 1'b1;
    end
  end

  assign idle = (state == ST_IDLE);

  // R4: a pending write waits while the bridge has no space
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txPend && !txeOk) |=> (txPend && state != ST_WSETUP));

  // R9: write wins when both directions could go
  assert_write_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && txPend && rxPend && txeOk && rxfOk) |=> (state == ST_WSETUP && rxPend));

endmodule

// File: rtl/pfbDatapath.sv
module pfbDatapath
  import pfbPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STROBE_CYC  = 2,
  parameter int RECOVER_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfbStrobe_t        stb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              wrN,
  output logic              rdN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int MAXC = (STROBE_CYC > RECOVER_CYC) ? STROBE_CYC : RECOVER_CYC;
  localparam int CW   = $clog2(MAXC + 2);

  logic [DATA_W-1:0] txHold;
  logic [CW-1:0]     wrLowCnt;
  logic [CW-1:0]     gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      busOut  <= '0;
      busOe   <= 1'b0;
      wrN     <= 1'b1;
      rdN     <= 1'b1;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.loadTx) txHold <= cpuWrData;
      if (stb.oeOn) begin
        busOut <= txHold;
        busOe  <= 1'b1;
      end else if (stb.oeOff) begin
        busOe  <= 1'b0;
      end
      if (stb.wrLow)       wrN <= 1'b0;
      else if (stb.wrHigh) wrN <= 1'b1;
      if (stb.rdLow)       rdN <= 1'b0;
      else if (stb.rdHigh) rdN <= 1'b1;
      if (stb.rdHigh) rdData <= busIn;
      rdValid <= stb.rdHigh;
    end
  end

  // Observers for the timing properties below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLowCnt <= '0;
      gapCnt   <= CW'(RECOVER_CYC);
    end else begin
      if (wrN)                    wrLowCnt <= '0;
      else if (wrLowCnt != '1)    wrLowCnt <= wrLowCnt + CW'(1);
      if (busOe || !rdN)                    gapCnt <= '0;
      else if (gapCnt != CW'(RECOVER_CYC))  gapCnt <= gapCnt + CW'(1);
    end
  end

  assert_bus_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!busOe && wrN));

  assert_wr_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busOe);

  assert_wr_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> (wrLowCnt == CW'(STROBE_CYC)));

  assert_recovery_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busOe) || $fell(rdN)) |-> (gapCnt >= CW'(RECOVER_CYC)));

  assert_rdvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/pfifoBridge.sv
module pfifoBridge #(
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RECOVER_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrReq,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdReq,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuRdValid,
  output logic              txReady,
  output logic              rxReady,
  output logic              busy,
  input  logic              rxfN,
  input  logic              txeN,
  output logic              rdN,
  output logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  pfbPkg::pfbStrobe_t stb;
  logic [1:0] syncQ;
  logic       txeOk, rxfOk;
  logic       txPend, rxPend, idle;

  pfbSync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) uSync (
    .clk(clk), .rstN(rstN), .din({rxfN, txeN}), .dout(syncQ)
  );

  assign txeOk = !syncQ[0];
  assign rxfOk = !syncQ[1];

  pfbCtl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) uCtl (
    .clk(clk), .rstN(rstN), .cpuWrReq(cpuWrReq), .cpuRdReq(cpuRdReq),
    .txeOk(txeOk), .rxfOk(rxfOk), .stb(stb),
    .txPend(txPend), .rxPend(rxPend), .idle(idle)
  );

  pfbDatapath #(
    .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWrData(cpuWrData), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .wrN(wrN), .rdN(rdN),
    .rdData(cpuRdData), .rdValid(cpuRdValid)
  );

  assign txReady = idle && !txPend && txeOk;
  assign rxReady = idle && !rxPend && rxfOk;
  assign busy    = !idle || txPend || rxPend;

  // R4: write window opens only after space was seen through the synchroniser
  assert_tx_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> $past(txeOk));

  // R6: read strobe starts only after data was seen through the synchroniser
  assert_rx_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(rxfOk));

  // R10: a free controller leaves the bridge alone
  assert_quiet_when_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rdN && wrN && !busOe));

endmodule

// File: tb/tb_pfifoBridge.sv
module tb_pfifoBridge;

  localparam int S  = 1;
  localparam int W  = 2;
  localparam int H  = 1;
  localparam int RC = 2;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWrReq = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic cpuRdReq = 1'b0;
  logic [7:0] cpuRdData;
  logic cpuRdValid, txReady, rxReady, busy;
  logic rxfN = 1'b1;
  logic txeN = 1'b1;
  logic rdN, wrN, busOe;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;

  pfifoBridge #(.DATA_W(8), .SETUP_CYC(S), .STROBE_CYC(W), .HOLD_CYC(H),
                .RECOVER_CYC(RC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cpuWrReq(cpuWrReq), .cpuWrData(cpuWrData),
    .cpuRdReq(cpuRdReq), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid),
    .txReady(txReady), .rxReady(rxReady), .busy(busy),
    .rxfN(rxfN), .txeN(txeN), .rdN(rdN), .wrN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] expTx[$];
  logic [7:0] gotTx[$];
  logic [7:0] rxQ[$];
  logic [7:0] gotRx[$];
  int startLog[$];
  bit txBlock = 1'b1;
  bit benchTxPend = 1'b0;
  bit benchRxPend = 1'b0;

  // monitor state
  int mPhase = 0, rPhase = 0;
  int setupCnt = 0, lowCnt = 0, holdCnt = 0, rLow = 0, gap = 1000;
  logic [7:0] curByte = 8'h00;
  logic prevOe = 1'b0, prevRd = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bridge model and per-clock reference checks, sampled 1 unit after each edge
  always @(posedge clk) begin
    bit rdRose;
    #1;
    rdRose = 1'b0;
    if (!rstN) begin
      mPhase = 0; rPhase = 0; gap = 1000;
      prevOe = 1'b0; prevRd = 1'b1;
      txeN = 1'b1; rxfN = 1'b1; busIn = 8'h00;
    end else begin
      chk(!(!rdN && (busOe || !wrN)), "R7 strobe/bus overlap", {rdN, wrN, busOe}, 3'b110);
      // write window tracking
      if (busOe && !prevOe) begin
        chk(mPhase == 0 && rPhase == 0, "R7 window start while busy", mPhase, 0);
        chk(gap >= RC, "R8 gap before write", gap, RC);
        startLog.push_back(1);
        benchTxPend = 1'b0;
        mPhase = 1; setupCnt = 0;
        chk(expTx.size() > 0, "R5 unexpected write", expTx.size(), 1);
        curByte = (expTx.size() > 0) ? expTx[0] : 8'hxx;
      end
      if (mPhase == 1 && !wrN) begin
        chk(setupCnt == S, "R3 setup cycles", setupCnt, S);
        mPhase = 2; lowCnt = 0;
      end
      if (mPhase == 2 && wrN) begin
        chk(lowCnt == W, "R3 write strobe width", lowCnt, W);
        gotTx.push_back(busOut);
        if (expTx.size() > 0) void'(expTx.pop_front());
        mPhase = 3; holdCnt = 0;
      end
      if (mPhase == 3 && !busOe) begin
        chk(holdCnt == H, "R3 hold cycles", holdCnt, H);
        mPhase = 0; gap = 0;
      end
      if (mPhase != 0) chk(busOe && busOut == curByte, "R3 bus data in window", busOut, curByte);
      if (mPhase == 0) chk(!busOe && wrN, "R7 bus released outside window", {busOe, wrN}, 2'b01);
      if (mPhase == 1) setupCnt++;
      if (mPhase == 2) lowCnt++;
      if (mPhase == 3) holdCnt++;
      // read tracking
      if (!rdN && prevRd) begin
        chk(gap >= RC, "R8 gap before read", gap, RC);
        chk(rxQ.size() > 0, "R6 read with no data", rxQ.size(), 1);
        startLog.push_back(2);
        benchRxPend = 1'b0;
        rPhase = 1; rLow = 0;
      end
      if (rPhase == 1 && rdN) begin
        rdRose = 1'b1;
        chk(rLow == W, "R6 read strobe width", rLow, W);
        if (rxQ.size() > 0) begin
          chk(cpuRdData == rxQ[0], "R6 captured byte", cpuRdData, rxQ[0]);
          gotRx.push_back(rxQ.pop_front());
        end
        rPhase = 0; gap = 0;
      end
      if (rPhase == 1) rLow++;
      chk(cpuRdValid == rdRose, "R6 valid pulse timing", cpuRdValid, rdRose);
      if (mPhase == 0 && rPhase == 0 && !busOe && rdN) gap++;
      // bridge status and data
      txeN  = txBlock || !wrN;
      rxfN  = (rxQ.size() == 0) || !rdN;
      busIn = (!rdN && rxQ.size() > 0) ? rxQ[0] : 8'h00;
      prevOe = busOe; prevRd = rdN;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic doWrite(input logic [7:0] b);
    @(posedge clk); #3;
    if (!benchTxPend) begin expTx.push_back(b); benchTxPend = 1'b1; end
    cpuWrData = b; cpuWrReq = 1'b1;
    @(posedge clk); #3;
    cpuWrReq = 1'b0;
  endtask

  task automatic doRead();
    @(posedge clk); #3;
    benchRxPend = 1'b1;
    cpuRdReq = 1'b1;
    @(posedge clk); #3;
    cpuRdReq = 1'b0;
  endtask

  task automatic doBoth(input logic [7:0] b);
    @(posedge clk); #3;
    if (!benchTxPend) begin expTx.push_back(b); benchTxPend = 1'b1; end
    benchRxPend = 1'b1;
    cpuWrData = b; cpuWrReq = 1'b1; cpuRdReq = 1'b1;
    @(posedge clk); #3;
    cpuWrReq = 1'b0; cpuRdReq = 1'b0;
  endtask

  task automatic waitQuiet();
    int n;
    n = 0;
    do begin
      @(posedge clk); #3; n++;
    end while ((busy || mPhase != 0 || rPhase != 0) && n < 2000);
    tick(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    rstN = 1'b0;
    tick(3);
    // R1 reset state
    chk(rdN && wrN && !busOe && !busy && !cpuRdValid, "R1 outputs in reset",
        {rdN, wrN, busOe, busy, cpuRdValid}, 5'b11000);
    rstN = 1'b1;
    tick(4);
    chk(rdN && wrN && !busOe && !busy, "R1 outputs after release", {rdN, wrN, busOe, busy}, 4'b1100);
    chk(!txReady && !rxReady, "R2 not ready while lines high", {txReady, rxReady}, 0);

    // R2 synchroniser latency on transmit side
    txBlock = 1'b0;
    tick(1);
    tick(1); chk(txReady == 1'b0, "R2 txReady after one edge", txReady, 0);
    tick(1); chk(txReady == 1'b1, "R2 txReady after two edges", txReady, 1);
    // R2 on receive side
    rxQ.push_back(8'h5A);
    tick(1);
    tick(1); chk(rxReady == 1'b0, "R2 rxReady after one edge", rxReady, 0);
    tick(1); chk(rxReady == 1'b1, "R2 rxReady after two edges", rxReady, 1);

    // R6 basic read
    doRead();
    chk(busy == 1'b1, "R10 busy after read request", busy, 1);
    waitQuiet();
    chk(gotRx.size() == 1 && gotRx[0] == 8'h5A, "R6 first read", gotRx.size(), 1);
    chk(!rxReady && !busy, "R10 quiet after read", {rxReady, busy}, 0);

    // R3 basic write
    doWrite(8'hA5);
    chk(busy == 1'b1, "R10 busy after write request", busy, 1);
    waitQuiet();
    chk(gotTx.size() == 1 && gotTx[gotTx.size()-1] == 8'hA5, "R3 byte sent", gotTx[gotTx.size()-1], 8'hA5);
    chk(txReady && !busy, "R10 ready after write", {txReady, busy}, 2'b10);

    // R4 write held while bridge full
    txBlock = 1'b1;
    tick(4);
    n0 = gotTx.size();
    doWrite(8'h3C);
    tick(30);
    chk(gotTx.size() == n0 && !busOe && wrN, "R4 no strobe while full", gotTx.size(), n0);
    chk(busy && !txReady, "R4 busy and not ready while held", {busy, txReady}, 2'b10);
    txBlock = 1'b0;
    waitQuiet();
    chk(gotTx.size() == n0 + 1 && gotTx[n0] == 8'h3C, "R4 held write sent", gotTx[gotTx.size()-1], 8'h3C);

    // R5 second request while first pending is dropped
    txBlock = 1'b1;
    tick(4);
    n0 = gotTx.size();
    doWrite(8'h11);
    doWrite(8'h22);
    tick(5);
    txBlock = 1'b0;
    waitQuiet();
    chk(gotTx.size() == n0 + 1, "R5 single strobe", gotTx.size(), n0 + 1);
    chk(gotTx[gotTx.size()-1] == 8'h11, "R5 first byte kept", gotTx[gotTx.size()-1], 8'h11);

    // R6 read held while bridge empty
    doRead();
    tick(20);
    chk(rdN && busy && !rxReady, "R6 read held with no data", {rdN, busy, rxReady}, 3'b110);
    n0 = gotRx.size();
    rxQ.push_back(8'h99);
    waitQuiet();
    chk(gotRx.size() == n0 + 1 && gotRx[n0] == 8'h99, "R6 held read done", gotRx[gotRx.size()-1], 8'h99);

    // R9 write before read when both can go
    rxQ.push_back(8'hC3);
    tick(4);
    n0 = startLog.size();
    doBoth(8'h77);
    waitQuiet();
    chk(startLog.size() == n0 + 2, "R9 two transfers", startLog.size(), n0 + 2);
    if (startLog.size() == n0 + 2)
      chk(startLog[n0] == 1 && startLog[n0+1] == 2, "R9 write first", startLog[n0], 1);

    // R8 back-to-back writes, gap checked by monitor
    n0 = gotTx.size();
    doWrite(8'h40);
    doWrite(8'h41);
    doWrite(8'h42);
    waitQuiet();
    chk(gotTx.size() >= n0 + 2, "R8 back-to-back writes", gotTx.size(), n0 + 2);

    // Mixed traffic with toggling space
    for (int i = 0; i < 8; i++) begin
      rxQ.push_back(8'h80 + 8'(i));
      txBlock = (i % 3 == 1);
      doWrite(8'h60 + 8'(i));
      doRead();
      tick(i % 4);
    end
    txBlock = 1'b0;
    waitQuiet();
    for (int k = 0; k < 20 && rxQ.size() > 0; k++) begin
      doRead();
      waitQuiet();
    end
    chk(rxQ.size() == 0, "R6 all received bytes fetched", rxQ.size(), 0);
    chk(expTx.size() == 0, "R5 every accepted write sent", expTx.size(), 0);
    chk(!busy && rdN && wrN && !busOe, "R10 idle at end", {busy, rdN, wrN, busOe}, 3'b110);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule